// File: doc/BRIEF.md
# Two-Level IO Page Table Walker

This block turns a 32-bit IO virtual address into a physical address. It reads descriptors from a two-level translation table in memory. A client hands over the virtual address together with the byte address of the first-level table. The walker then fetches one 32-bit descriptor at a time through a simple memory port, where a request handshake is followed later by a single response beat. It finishes with a one-cycle result that carries the physical address, the mapping granule, or a fault marker.

At the first level, the low two descriptor bits pick one of three outcomes:
- a 1 MB direct mapping,
- a pointer to a 256-entry second-level table,
- a fault.

At the second level, the same two bits pick a 4 KB page, a 64 KB page or a fault. A 64 KB page occupies 16 neighbouring second-level slots that all hold the same descriptor, so any of those slots gives the same translation. The walker handles one walk at a time and accepts no new request until the current result has been delivered.

Top module: `iopt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `req_ready` is 1, `res_valid` is 0 and `mem_req_valid` is 0.
- R2: The first descriptor read goes to `req_base + req_va[31:20]*4`.
- R3: A first-level descriptor whose bits[1:0] are 2 ends the walk after that one read. It gives `res_fault`=0, `res_size`=2 (1 MB) and `res_pa` = {descriptor[31:20], va[19:0]}.
- R4: A first-level descriptor whose bits[1:0] are 0 or 3 ends the walk after one read. It gives `res_fault`=1, `res_fault_lvl`=0, `res_size`=0 and `res_pa`=0. Whenever `res_fault` is 0, `res_fault_lvl` is 0.
- R5: A first-level descriptor whose bits[1:0] are 1 causes a second read at {descriptor[31:10], va[19:12], 2'b00}. Descriptor bits [9:2] play no part in that address.
- R6: A second-level descriptor whose bits[1:0] are 1 gives `res_size`=1 (64 KB) and `res_pa` = {descriptor[31:16], va[15:0]}.
- R7: A second-level descriptor with bit 1 set, whatever bit 0 holds, gives `res_size`=0 (4 KB) and `res_pa` = {descriptor[31:12], va[11:0]}.
- R8: A second-level descriptor whose bits[1:0] are 0 gives `res_fault`=1, `res_fault_lvl`=1, `res_size`=0 and `res_pa`=0.
- R9: Each accepted request produces exactly one `res_valid` pulse, one cycle long. `res_va` carries the request's virtual address.
- R10: At most one memory read is outstanding. A read request holds its address until it is accepted. `req_ready` is 0 from acceptance until the result cycle, and requests offered in that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request accepted this cycle if offered |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | Byte address of the first-level table |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | One-cycle result strobe |
| res_pa | output | 32 | Physical address (0 on fault) |
| res_size | output | 2 | Granule: 0 = 4 KB, 1 = 64 KB, 2 = 1 MB |
| res_fault | output | 1 | Translation fault |
| res_fault_lvl | output | 1 | Faulting level: 0 = first, 1 = second |
| res_va | output | 32 | Virtual address of the finished walk |

## Verification
The bench builds sparse tables that contain every descriptor code at both levels. This includes code 3, which faults at the first level but is a small page at the second. A decoder that tested only bit 1 at the first level, or that required exactly 2 at the second, would return the wrong granule or a spurious fault.

Table pointers carry junk in bits [9:2], and sections carry junk in their middle bits. A walker that failed to mask them would read the wrong second-level slot or leak descriptor bits into the page offset.

Large pages are probed at the last slot of their 16-entry group. The top table index 4095 is probed with a second table base. A random stall and latency on the memory port, together with requests offered mid-walk, expose a walker that drops its read address or starts a second walk early.

// File: rtl/iopt_walk_pkg.sv
package iopt_walk_pkg;

    localparam int ADDR_W          = 32;
    localparam int SECT_SHIFT      = 20;
    localparam int LARGE_SHIFT     = 16;
    localparam int SMALL_SHIFT     = 12;
    localparam int DESC_BYTES_LOG2 = 2;
    localparam int L1_IDX_W        = ADDR_W - SECT_SHIFT;
    localparam int L2_IDX_W        = SECT_SHIFT - SMALL_SHIFT;
    localparam int L2_BASE_LSB     = L2_IDX_W + DESC_BYTES_LOG2;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_RD,
        ST_L1_WT,
        ST_L2_RD,
        ST_L2_WT,
        ST_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        SZ_4K  = 2'd0,
        SZ_64K = 2'd1,
        SZ_1M  = 2'd2
    } pg_size_e;

    typedef enum logic [1:0] {
        L1_FAULT,
        L1_SECT,
        L1_TABLE
    } l1_kind_e;

    typedef enum logic {
        LVL_FIRST  = 1'b0,
        LVL_SECOND = 1'b1
    } walk_lvl_e;

    typedef struct packed {
        addr_t     pa;
        pg_size_e  size;
        logic      fault;
        walk_lvl_e lvl;
    } walk_res_t;

    // Upper bits from hi_src, low `shift` bits from lo_src.
    function automatic addr_t splice(addr_t hi_src, addr_t lo_src, int unsigned shift);
        addr_t m;
        m = (addr_t'(1) << shift) - addr_t'(1);
        return (hi_src & ~m) | (lo_src & m);
    endfunction

    function automatic addr_t l1_slot_addr(addr_t base, addr_t va);
        addr_t idx;
        idx = va >> SECT_SHIFT;
        return base + (idx << DESC_BYTES_LOG2);
    endfunction

    function automatic addr_t l2_slot_addr(addr_t desc, addr_t va);
        addr_t tbl;
        addr_t idx;
        tbl = (desc >> L2_BASE_LSB) << L2_BASE_LSB;
        idx = (va >> SMALL_SHIFT) & ((addr_t'(1) << L2_IDX_W) - addr_t'(1));
        return tbl | (idx << DESC_BYTES_LOG2);
    endfunction

endpackage

// File: rtl/iopt_l1_dec.sv
module iopt_l1_dec
    import iopt_walk_pkg::*;
(
    input  addr_t    desc,
    input  addr_t    va,
    output l1_kind_e kind,
    output addr_t    sect_pa,
    output addr_t    next_addr
);

    always_comb begin
        unique case (desc[1:0])
            2'b10:   kind = L1_SECT;
            2'b01:   kind = L1_TABLE;
            default: kind = L1_FAULT;
        endcase
    end

    assign sect_pa   = splice(desc, va, SECT_SHIFT);
    assign next_addr = l2_slot_addr(desc, va);

endmodule

// File: rtl/iopt_l2_dec.sv
module iopt_l2_dec
    import iopt_walk_pkg::*;
(
    input  addr_t     desc,
    input  addr_t     va,
    output walk_res_t res
);

    always_comb begin
        res = '{pa: '0, size: SZ_4K, fault: 1'b1, lvl: LVL_SECOND};
        if (desc[1]) begin
            res.pa    = splice(desc, va, SMALL_SHIFT);
            res.fault = 1'b0;
            res.lvl   = LVL_FIRST;
        end else if (desc[0]) begin
            res.pa    = splice(desc, va, LARGE_SHIFT);
            res.size  = SZ_64K;
            res.fault = 1'b0;
            res.lvl   = LVL_FIRST;
        end
    end

endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
    import iopt_walk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    input  logic [ADDR_W-1:0] req_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_pa,
    output logic [1:0]        res_size,
    output logic              res_fault,
    output logic              res_fault_lvl,
    output logic [ADDR_W-1:0] res_va
);

    walk_st_e  st_q;
    addr_t     va_q;
    addr_t     rd_addr_q;
    walk_res_t res_q;

    l1_kind_e  l1_kind;
    addr_t     l1_sect_pa;
    addr_t     l1_next;
    walk_res_t l2_res;

    iopt_l1_dec u_l1_dec (
        .desc      (mem_rsp_data),
        .va        (va_q),
        .kind      (l1_kind),
        .sect_pa   (l1_sect_pa),
        .next_addr (l1_next)
    );

    iopt_l2_dec u_l2_dec (
        .desc (mem_rsp_data),
        .va   (va_q),
        .res  (l2_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            va_q      <= '0;
            rd_addr_q <= '0;
            res_q     <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q      <= req_va;
                        rd_addr_q <= l1_slot_addr(req_base, req_va);
                        st_q      <= ST_L1_RD;
                    end
                end
                ST_L1_RD: begin
                    if (mem_req_ready) st_q <= ST_L1_WT;
                end
                ST_L1_WT: begin
                    if (mem_rsp_valid) begin
                        unique case (l1_kind)
                            L1_SECT: begin
                                res_q <= '{pa: l1_sect_pa, size: SZ_1M,
                                           fault: 1'b0, lvl: LVL_FIRST};
                                st_q  <= ST_DONE;
                            end
                            L1_TABLE: begin
                                rd_addr_q <= l1_next;
                                st_q      <= ST_L2_RD;
                            end
                            default: begin
                                res_q <= '{pa: '0, size: SZ_4K,
                                           fault: 1'b1, lvl: LVL_FIRST};
                                st_q  <= ST_DONE;
                            end
                        endcase
                    end
                end
                ST_L2_RD: begin
                    if (mem_req_ready) st_q <= ST_L2_WT;
                end
                ST_L2_WT: begin
                    if (mem_rsp_valid) begin
                        res_q <= l2_res;
                        st_q  <= ST_DONE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (st_q == ST_IDLE);
    assign mem_req_valid = (st_q == ST_L1_RD) || (st_q == ST_L2_RD);
    assign mem_req_addr  = rd_addr_q;
    assign res_valid     = (st_q == ST_DONE);
    assign res_pa        = res_q.pa;
    assign res_size      = res_q.size;
    assign res_fault     = res_q.fault;
    assign res_fault_lvl = res_q.lvl;
    assign res_va        = va_q;

endmodule

// File: rtl/iopt_walker_chk.sv
module iopt_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        res_valid,
    input logic [31:0] res_pa,
    input logic [1:0]  res_size,
    input logic        res_fault,
    input logic        res_fault_lvl,
    input logic [19:0] res_va_lo
);

    // R10: a stalled read keeps its request and address
    a_r10_hold_read: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R10: no descriptor read while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid);

    // R9: result strobe lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R10: not ready in the result cycle
    a_r10_busy_at_result: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !req_ready);

    // R3: section keeps 20 offset bits
    a_r3_sect_offset: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_fault && res_size == 2'd2 |-> res_pa[19:0] == res_va_lo);

    // R6: large page keeps 16 offset bits
    a_r6_large_offset: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_fault && res_size == 2'd1 |-> res_pa[15:0] == res_va_lo[15:0]);

    // R7: small page keeps 12 offset bits
    a_r7_small_offset: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_fault && res_size == 2'd0 |-> res_pa[11:0] == res_va_lo[11:0]);

    // R4 / R8: a fault carries zero address and size
    a_r8_fault_zero: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_fault |-> res_pa == 32'd0 && res_size == 2'd0);

    // R4: level bit only set on a fault
    a_r4_lvl_on_fault: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_fault |-> !res_fault_lvl);

    // R3: size code 3 never appears
    a_r3_size_legal: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_size != 2'd3);

endmodule

bind iopt_walker iopt_walker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .res_valid     (res_valid),
    .res_pa        (res_pa),
    .res_size      (res_size),
    .res_fault     (res_fault),
    .res_fault_lvl (res_fault_lvl),
    .res_va_lo     (res_va[19:0])
);

// File: tb/iopt_walker_bench.sv
module iopt_walker_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_va;
    logic [31:0] req_base;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        res_valid;
    logic [31:0] res_pa;
    logic [1:0]  res_size;
    logic        res_fault;
    logic        res_fault_lvl;
    logic [31:0] res_va;

    always #10 clk = ~clk;

    iopt_walker u_iopt_walker (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .req_base      (req_base),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .res_valid     (res_valid),
        .res_pa        (res_pa),
        .res_size      (res_size),
        .res_fault     (res_fault),
        .res_fault_lvl (res_fault_lvl),
        .res_va        (res_va)
    );

    localparam logic [31:0] BASE_A = 32'h0010_0000;
    localparam logic [31:0] BASE_B = 32'h0020_0000;

    logic [31:0] mem_q [logic [31:0]];
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_addr [4];
    int unsigned idx_l [32];

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem_q.exists(a) ? mem_q[a] : 32'd0;
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Reference translation from the requirements
    task automatic model(input logic [31:0] va, input logic [31:0] base,
                         output logic [31:0] pa, output logic [1:0] sz,
                         output logic flt, output logic lvl, output int nrd,
                         output logic [31:0] a0, output logic [31:0] a1,
                         output string rq);
        logic [31:0] e1;
        logic [31:0] e2;
        a0 = base + {18'd0, va[31:20], 2'b00};
        a1 = 32'd0; nrd = 1; pa = 32'd0; sz = 2'd0; flt = 1'b0; lvl = 1'b0;
        e1 = rd(a0);
        if (e1[1:0] == 2'd2) begin
            pa = {e1[31:20], va[19:0]}; sz = 2'd2; rq = "R3";
        end else if (e1[1:0] == 2'd1) begin
            a1  = {e1[31:10], va[19:12], 2'b00};
            nrd = 2;
            e2  = rd(a1);
            if (e2[1]) begin
                pa = {e2[31:12], va[11:0]}; rq = "R7";
            end else if (e2[0]) begin
                pa = {e2[31:16], va[15:0]}; sz = 2'd1; rq = "R6";
            end else begin
                flt = 1'b1; lvl = 1'b1; rq = "R8";
            end
        end else begin
            flt = 1'b1; rq = "R4";
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] base, input bit busy);
        logic [31:0] pa, a0, a1;
        logic [1:0]  sz;
        logic        flt, lvl;
        int          nrd, cyc;
        string       rq;
        model(va, base, pa, sz, flt, lvl, nrd, a0, a1, rq);
        @(negedge clk);
        rd_cnt    = 0;
        req_valid = 1'b1; req_va = va; req_base = base;
        @(negedge clk);
        if (busy) begin
            req_va = ~va; req_base = base ^ 32'h0000_4000;
        end else begin
            req_valid = 1'b0;
        end
        cyc = 0;
        while (!res_valid && cyc < 60) begin
            if (busy) chk("R10", "ready during walk", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        if (!res_valid) begin
            chk("R9", "result timeout", 32'd0, 32'd1);
        end else begin
            chk(rq, "pa", res_pa, pa);
            chk(rq, "size", {30'd0, res_size}, {30'd0, sz});
            chk(rq, "fault", {31'd0, res_fault}, {31'd0, flt});
            chk(rq, "fault level", {31'd0, res_fault_lvl}, {31'd0, lvl});
            chk("R9", "echoed va", res_va, va);
            chk("R2", "first read addr", rd_addr[0], a0);
            if (nrd == 2) chk("R5", "second read addr", rd_addr[1], a1);
            @(negedge clk);
            chk("R9", "pulse width", {31'd0, res_valid}, 32'd0);
            repeat (2) @(negedge clk);
            chk(busy ? "R10" : rq, "reads per walk", rd_cnt, nrd);
            if (busy) chk("R10", "no walk from busy offer", {31'd0, mem_req_valid}, 32'd0);
        end
    endtask

    // Memory model: random accept stall, 0..2 cycle response latency
    initial begin : responder
        bit          pend = 0;
        int          lat = 0;
        logic [31:0] pend_addr = 32'd0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = 32'd0;
        forever begin
            @(posedge clk);
            if (mem_req_valid && mem_req_ready) begin
                pend = 1; pend_addr = mem_req_addr; lat = int'($urandom % 3);
                if (rd_cnt < 4) rd_addr[rd_cnt] = mem_req_addr;
                rd_cnt++;
            end
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_req_ready = ($urandom % 4) != 0;
            if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1; mem_rsp_data = rd(pend_addr); pend = 0;
                end else begin
                    lat--;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'd7;
        void'($urandom(seed));
        rst = 1'b1; req_valid = 1'b0; req_va = '0; req_base = '0;
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", {31'd0, req_ready}, 32'd1);
        chk("R1", "result in reset", {31'd0, res_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1", "read after reset", {31'd0, mem_req_valid}, 32'd0);
        chk("R1", "result after reset", {31'd0, res_valid}, 32'd0);

        // Directed corners
        mem_q[BASE_B + 32'd4095*4] = 32'hABCF_FFF6;               // section, top index
        walk(32'hFFF1_2345, BASE_B, 0);                           // R3, R2
        mem_q[BASE_A + 32'd5*4] = 32'h1234_5673;                  // code 3 at L1
        walk(32'h0058_9ABC, BASE_A, 0);                           // R4
        mem_q[BASE_A + 32'd4*4] = 32'h0000_0000;                  // code 0 at L1
        walk(32'h0040_0000, BASE_A, 0);                           // R4
        mem_q[BASE_A + 32'd6*4] = 32'h0900_03FD;                  // table, junk in [9:2]
        mem_q[32'h0900_0000 + 32'h37*4] = 32'h5555_5FFF;          // code 3 at L2: small
        walk(32'h0063_7ABC, BASE_A, 0);                           // R5, R7
        for (int s = 0; s < 16; s++) mem_q[32'h0900_0000 + (32'h40 + s)*4] = 32'h7777_0001;
        walk(32'h0064_F123, BASE_A, 0);                           // R6, last slot of group
        walk(32'h0064_0FED, BASE_A, 0);                           // R6, first slot
        walk(32'h0065_0000, BASE_A, 0);                           // R8, empty slot
        walk(32'h0063_7001, BASE_A, 1);                           // R10, busy offer

        // Random tables
        for (int n = 0; n < 32; n++) begin
            int unsigned ix, kind;
            logic [31:0] a, tb;
            ix = $urandom_range(0, 4095);
            idx_l[n] = ix;
            kind = $urandom % 4;
            a  = BASE_A + ix*4;
            tb = 32'h0A00_0000 + n*1024;
            case (kind)
                0: mem_q[a] = ($urandom & ~32'd3) | 32'd2;
                1: begin
                    mem_q[a] = tb | ($urandom & 32'h3FC) | 32'd1;
                    for (int g = 0; g < 16; g++) begin
                        int unsigned gk;
                        logic [31:0] le;
                        gk = $urandom % 4;
                        le = ($urandom & ~32'd3) | 32'd1;
                        for (int s = 0; s < 16; s++) begin
                            logic [31:0] sa;
                            sa = tb + (g*16 + s)*4;
                            case (gk)
                                0: mem_q[sa] = 32'd0;
                                1: mem_q[sa] = le;
                                2: mem_q[sa] = ($urandom & ~32'd3) | 32'd2 | ($urandom % 2);
                                default: mem_q[sa] = ($urandom % 2) ? (($urandom & ~32'd3) | 32'd2) : 32'd0;
                            endcase
                        end
                    end
                end
                2: mem_q[a] = $urandom | 32'd3;
                default: mem_q[a] = $urandom & ~32'd3;
            endcase
        end
        for (int k = 0; k < 200; k++) begin
            logic [31:0] va;
            logic [19:0] lo;
            logic [11:0] hi;
            lo = 20'($urandom);
            hi = 12'(idx_l[$urandom % 32]);
            va = (k % 10 == 9) ? $urandom : {hi, lo};
            walk(va, BASE_A, ($urandom % 8) == 0);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule